// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block recovers 8-bit characters from an asynchronous serial line: a start bit (low), eight data bits sent least-significant first, then one stop bit (high). It has no access to the sender's clock. An internal phase accumulator produces a sampling tick at eight times the bit rate. On each tick the raw line is brought into the clock domain by two flip-flops. A small saturating counter then cleans the synchronised line, so that brief spikes cannot look like a start bit.

A bit sequencer watches the cleaned line. When it sees a falling edge, it aligns a three-bit tick counter so that every later bit is sampled near the middle of its period. It then shifts the eight data bits into a byte register, each new bit entering at the top position. When a frame ends in a valid stop bit, a strobe rises for exactly one system clock. The byte is to be read while that strobe is high.

The block suits any design that needs a compact receive-only serial port. The clock rate and bit rate are parameters.

Top module: `uart_rx_os`

## Requirements
- R1: After synchronous reset, `rx_valid` is low and no strobe is raised while the line stays idle (high).
- R2: The byte presented with the strobe takes the first data bit on the line as bit 0 and the last data bit as bit 7.
- R3: Each frame with a high stop bit produces exactly one `rx_valid` pulse, and that pulse lasts exactly one clock cycle.
- R4: The strobe comes between 9.5 and 11 bit periods after the falling edge of the start bit.
- R5: A low spike on the idle line lasting one or two sampling ticks produces no strobe, and the next frame is still received correctly.
- R6: A frame whose stop bit is low produces no strobe. The receiver then waits for the line to return high before it looks for a new start bit, so a following good frame is received correctly.
- R7: Frames whose bit period differs from the nominal period by up to ±2 % are received correctly.
- R8: Frames sent back to back, each with a single stop bit and no idle gap, are all received, in order.
- R9: `rx_byte` holds the received value after the strobe for as long as the line stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_byte | output | 8 | Assembled byte; valid while `rx_valid` is high |
| rx_valid | output | 1 | One-cycle strobe marking a complete, well-framed byte |

## Verification
On every cycle, the assertions check the following:
- the sampling tick never fires on two adjacent clocks;
- the cleaned line changes only after its counter has reached the matching extreme;
- the sequencer state and the byte register move only after a tick;
- the strobe is a single cycle, follows a tick, and leaves the machine idle.

Only the bench scenarios can show the end-to-end behaviour:
- that the bits are ordered correctly;
- that spikes of one and two ticks are rejected;
- that a missing stop bit is handled and the receiver recovers;
- that it tolerates a rate offset;
- that it keeps up with back-to-back frames;
- that the strobe falls inside the expected time window.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    // Sampling ticks per bit period; the spacing counter width follows.
    localparam int OSR       = 8;
    localparam int SPC_W     = $clog2(OSR);
    localparam int BYTE_W    = 8;
    // Hysteresis counter width and its saturation value.
    localparam int FILT_W    = 2;
    localparam int FILT_MAX  = (1 << FILT_W) - 1;
    // Spacing value loaded while idle: first bit taken OSR/2 ticks after the edge.
    localparam logic [SPC_W-1:0] SPC_ALIGN = SPC_W'(OSR / 2);

    // Data phase is marked by bit 3; the other codes are control states.
    typedef enum logic [3:0] {
        ST_IDLE  = 4'b0000,
        ST_START = 4'b0001,
        ST_STOP  = 4'b0010,
        ST_HOLD  = 4'b0011,
        ST_D0    = 4'b1000,
        ST_D1    = 4'b1001,
        ST_D2    = 4'b1010,
        ST_D3    = 4'b1011,
        ST_D4    = 4'b1100,
        ST_D5    = 4'b1101,
        ST_D6    = 4'b1110,
        ST_D7    = 4'b1111
    } rx_state_e;

    // Conditioned line as handed from the filter to the sequencer.
    typedef struct packed {
        logic tick;
        logic level;
    } line_s;

    // Increment that makes the accumulator overflow OSR times per bit.
    function automatic longint unsigned phase_inc(input longint unsigned clk_hz,
                                                  input longint unsigned baud,
                                                  input int              acc_w);
        return ((baud * OSR) << acc_w) / clk_hz;
    endfunction

    function automatic logic in_data(input rx_state_e s);
        return s[3];
    endfunction

    function automatic rx_state_e after_data(input rx_state_e s);
        return (s == ST_D7) ? ST_STOP : rx_state_e'(s + 4'd1);
    endfunction

endpackage

// File: rtl/uart_os_tick.sv
module uart_os_tick #(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned BAUD   = 115_200,
    parameter int          ACC_W  = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    import uart_rx_pkg::*;

    localparam logic [ACC_W-1:0] INC = ACC_W'(phase_inc(CLK_HZ, BAUD, ACC_W));

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;
    logic             tick_q;

    assign sum  = {1'b0, acc_q} + {1'b0, INC};
    assign tick = tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= sum[ACC_W-1:0];
            tick_q <= sum[ACC_W];
        end
    end

    // R4: sampling rate below half the clock, so ticks are isolated
    p_tick_isolated_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/uart_line_filter.sv
module uart_line_filter (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                rxd,
    output uart_rx_pkg::line_s  line
);
    import uart_rx_pkg::*;

    logic [1:0]        sync_q;
    logic [FILT_W-1:0] cnt_q;
    logic              filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            cnt_q  <= FILT_W'(FILT_MAX);
            filt_q <= 1'b1;
        end else if (tick) begin
            sync_q <= {sync_q[0], rxd};
            if (sync_q[1] && cnt_q != FILT_W'(FILT_MAX))
                cnt_q <= cnt_q + 1'b1;
            else if (!sync_q[1] && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            if (cnt_q == FILT_W'(FILT_MAX))
                filt_q <= 1'b1;
            else if (cnt_q == '0)
                filt_q <= 1'b0;
        end
    end

    assign line.tick  = tick;
    assign line.level = filt_q;

    // R5: cleaned line only rises after saturating high, falls after reaching zero
    p_rise_saturated_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(filt_q) |-> ($past(cnt_q) == FILT_W'(FILT_MAX)));
    p_fall_empty_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(filt_q) |-> ($past(cnt_q) == '0));
    p_filt_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(filt_q));

endmodule

// File: rtl/uart_bit_seq.sv
module uart_bit_seq (
    input  logic                    clk,
    input  logic                    rst,
    input  uart_rx_pkg::line_s      line,
    output logic [uart_rx_pkg::BYTE_W-1:0] rx_byte,
    output logic                    rx_valid
);
    import uart_rx_pkg::*;

    rx_state_e         st_q;
    logic [SPC_W-1:0]  spc_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              vld_q;
    logic              next_bit;

    assign next_bit = (spc_q == {SPC_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            spc_q   <= SPC_ALIGN;
            shreg_q <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (line.tick) begin
                spc_q <= spc_q + 1'b1;
                case (st_q)
                    ST_IDLE: begin
                        // Hold the spacing counter aligned until the edge arrives.
                        spc_q <= SPC_ALIGN;
                        if (!line.level) st_q <= ST_START;
                    end
                    ST_START: begin
                        if (next_bit) st_q <= line.level ? ST_IDLE : ST_D0;
                    end
                    ST_STOP: begin
                        if (next_bit) begin
                            if (line.level) begin
                                vld_q <= 1'b1;
                                st_q  <= ST_IDLE;
                            end else begin
                                st_q  <= ST_HOLD;
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (line.level) st_q <= ST_IDLE;
                    end
                    default: begin
                        if (in_data(st_q)) begin
                            if (next_bit) begin
                                shreg_q <= {line.level, shreg_q[BYTE_W-1:1]};
                                st_q    <= after_data(st_q);
                            end
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                endcase
            end
        end
    end

    assign rx_byte  = shreg_q;
    assign rx_valid = vld_q;

    // R3: strobe is a single cycle, follows a tick, and leaves the machine idle
    p_valid_single_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
    p_valid_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(line.tick));
    p_valid_idle_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (st_q == ST_IDLE));
    // R9: byte register only moves after a tick
    p_byte_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !line.tick |=> $stable(rx_byte));
    // R4: sequencing advances only on sampling ticks
    p_state_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        !line.tick |=> $stable(st_q));
    // R6: a failed stop sample never yields a strobe
    p_hold_no_valid_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD) |=> !rx_valid);

endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os #(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned BAUD   = 115_200,
    parameter int          ACC_W  = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    output logic [7:0] rx_byte,
    output logic       rx_valid
);
    import uart_rx_pkg::*;

    logic  os_tick;
    line_s line;

    uart_os_tick #(
        .CLK_HZ (CLK_HZ),
        .BAUD   (BAUD),
        .ACC_W  (ACC_W)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (os_tick)
    );

    uart_line_filter u_filt (
        .clk  (clk),
        .rst  (rst),
        .tick (os_tick),
        .rxd  (rxd),
        .line (line)
    );

    uart_bit_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .line     (line),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

endmodule

// File: tb/sim_uart_rx_os.sv
module sim_uart_rx_os;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 64;      // 7.3728 MHz clock / 115200 baud
    localparam int LIMIT      = 150_000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;

    int         nvalid    = 0;
    int         last_cyc  = 0;
    logic [7:0] last_byte = 8'h00;
    logic [7:0] log_q [8];
    int         wide_err  = 0;
    logic       prev_v    = 1'b0;
    int         start_cyc = 0;

    uart_rx_os #(.CLK_HZ(7_372_800), .BAUD(115_200), .ACC_W(16)) u0 (
        .clk      (clk),
        .rst      (rst),
        .rxd      (rxd),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                log_q[nvalid % 8] = rx_byte;
                nvalid    = nvalid + 1;
                last_byte = rx_byte;
                last_cyc  = cyc;
                if (prev_v) wide_err = wide_err + 1;
            end
            prev_v = rx_valid;
        end
    end

    always @(posedge clk) begin
        if (cyc > LIMIT) begin
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", vectors + 1, fails + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input int bclk, input logic stop);
        @(negedge clk);
        rxd = 1'b0;
        start_cyc = cyc;
        hold(bclk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            hold(bclk);
        end
        rxd = stop;
        hold(bclk);
        rxd = 1'b1;
    endtask

    // One frame with idle gap; checks count, value and timing
    task automatic t_frame(input logic [7:0] b, input int bclk, input string req);
        int n0;
        int dt;
        n0 = nvalid;
        send_frame(b, bclk, 1'b1);
        hold(3 * bclk);
        chk(nvalid == n0 + 1, {req, "/R3 strobe count"}, nvalid - n0, 1);
        chk(last_byte == b, {req, "/R2 byte value"}, int'(last_byte), int'(b));
        dt = last_cyc - start_cyc;
        chk(dt >= (bclk * 19) / 2 && dt <= bclk * 11, {req, "/R4 strobe latency"}, dt, bclk * 10);
        chk(rx_byte == b, {req, "/R9 byte held"}, int'(rx_byte), int'(b));
    endtask

    task automatic t_reset;
        hold(200);
        chk(rx_valid == 1'b0, "R1 valid low after reset", int'(rx_valid), 0);
        chk(nvalid == 0, "R1 no strobe while idle", nvalid, 0);
    endtask

    task automatic t_basic;
        t_frame(8'hA5, BIT_CLKS, "R2 pattern A5");
        t_frame(8'h00, BIT_CLKS, "R2 all zero");
        t_frame(8'hFF, BIT_CLKS, "R2 all one");
        t_frame(8'h01, BIT_CLKS, "R2 lsb only");
        t_frame(8'h80, BIT_CLKS, "R2 msb only");
    endtask

    task automatic t_drift;
        t_frame(8'h3C, BIT_CLKS - 1, "R7 slow clock");
        t_frame(8'hC3, BIT_CLKS + 1, "R7 fast clock");
        t_frame(8'h69, BIT_CLKS + 1, "R7 fast clock 2");
    endtask

    task automatic t_glitch;
        int n0;
        n0 = nvalid;
        rxd = 1'b0; hold(8);  rxd = 1'b1; hold(300);
        rxd = 1'b0; hold(16); rxd = 1'b1; hold(800);
        chk(nvalid == n0, "R5 spikes rejected", nvalid - n0, 0);
        t_frame(8'h5A, BIT_CLKS, "R5 frame after spikes");
    endtask

    task automatic t_bad_stop;
        int n0;
        n0 = nvalid;
        send_frame(8'h77, BIT_CLKS, 1'b0);
        rxd = 1'b0;
        hold(2 * BIT_CLKS);
        rxd = 1'b1;
        hold(12 * BIT_CLKS);
        chk(nvalid == n0, "R6 low stop bit gives no strobe", nvalid - n0, 0);
        t_frame(8'h99, BIT_CLKS, "R6 recovery frame");
    endtask

    task automatic t_b2b;
        int n0;
        n0 = nvalid;
        send_frame(8'h12, BIT_CLKS, 1'b1);
        send_frame(8'hED, BIT_CLKS, 1'b1);
        send_frame(8'h4B, BIT_CLKS, 1'b1);
        hold(3 * BIT_CLKS);
        chk(nvalid == n0 + 3, "R8 back-to-back count", nvalid - n0, 3);
        chk(log_q[n0 % 8] == 8'h12, "R8 first byte", int'(log_q[n0 % 8]), 'h12);
        chk(log_q[(n0 + 1) % 8] == 8'hED, "R8 second byte", int'(log_q[(n0 + 1) % 8]), 'hED);
        chk(log_q[(n0 + 2) % 8] == 8'h4B, "R8 third byte", int'(log_q[(n0 + 2) % 8]), 'h4B);
    endtask

    initial begin
        rst = 1'b1;
        rxd = 1'b1;
        hold(5);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_drift();
        t_glitch();
        t_bad_stop();
        t_b2b();
        chk(wide_err == 0, "R3 strobe width one cycle", wide_err, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule